// File: doc/BRIEF.md
# Voltage Regulator Soft-Start Sequencer

This block walks the reference DAC of a voltage regulator from zero up to its regulation target in single-LSB steps once the supply and enable conditions are satisfied. Each DAC step is worth 6.25 mV, and steps are paced by a tick from an external soft-start oscillator. Fixed waiting periods are counted in system-clock cycles and set by parameters. The block then reports the finished start-up on a power-good flag.

Two sequences are supported. The mode is latched when the sequence starts.

- **Boot mode:** a start delay, then a first ramp up to the boot level (code 176, 1.1 V). The boot level is held for a fixed time, and at the end of that hold the target is sampled. A second ramp then moves from the boot level to the target, upward or downward.
- **Direct modes:** the target is sampled at once. After the start delay, a single ramp goes from zero to the target.
- **5-bit direct variant:** this variant also refuses to leave shutdown while the raw VID carries the no-load code.

Losing any rail or enable condition returns the block to shutdown at any point.

The target arrives already converted to a DAC code on `tgt_code`, with `tgt_valid` marking whether it is a legal code. All pins are plain level or pulse signals. No data stream crosses the boundary, so there is no handshake.

Top module: `vr_softstart_seq`

## Requirements
- R1: After reset, and whenever the block is in shutdown, `dac_code` is 0 and `busy`, `pgood` and `vid_strobe` are 0.
- R2: A sequence starts only in a cycle where `bias_ok`, `en_ok` and `drv_ok` are all 1. If any of them is 0, the block stays in shutdown.
- R3: With `mode` = 2'b10 (5-bit direct), the block does not start while `vid_code[4:0]` is 5'b11111. This check applies only before start; the code appearing later has no effect. The other modes ignore this code.
- R4: In boot mode (`mode` = 2'b00), `dac_code` stays 0 for `T_START` cycles after start. It then rises by one per tick until it equals `BOOT_CODE` (176).
- R5: In boot mode, `dac_code` holds at `BOOT_CODE` for `T_HOLD` cycles. Then `vid_strobe` pulses for exactly one cycle, `T_HOLD`+1 cycles after `dac_code` first shows `BOOT_CODE`. `tgt_code` and `tgt_valid` are latched on that pulse.
- R6: The second boot-mode ramp steps from `BOOT_CODE` toward the latched target, upward or downward. Changes of `tgt_code` after the latch have no effect.
- R7: If `tgt_valid` is 0 when it is latched in boot mode, `dac_code` stays at `BOOT_CODE`, `busy` stays 1 and `pgood` stays 0 until shutdown.
- R8: In direct mode (`mode` = 2'b01, 2'b10 or 2'b11), `vid_strobe` pulses in the first cycle after start and the target is latched there. After `T_START` cycles, a single ramp runs from 0 straight to the target.
- R9: `pgood` rises exactly `T_PG`+1 cycles after `dac_code` first equals the latched target. At that point `busy` falls and `dac_code` stays at the target.
- R10: If `bias_ok`, `en_ok` or `drv_ok` is 0 in any cycle, the next cycle shows `dac_code` = 0 and `busy` = `pgood` = 0.
- R11: `dac_code` changes by at most one per cycle while running, and only in a cycle that follows a 1 on `ss_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bias_ok | input | 1 | Controller bias above its power-on threshold |
| en_ok | input | 1 | Qualified enable |
| drv_ok | input | 1 | Driver bias above its power-on threshold |
| mode | input | 2 | 00 boot, 01 direct 6-bit, 10 direct 5-bit, 11 direct 6-bit |
| vid_code | input | VIDW | Raw VID pins, used for the no-load check |
| tgt_code | input | DW | Target DAC code converted from the VID |
| tgt_valid | input | 1 | Target code is legal |
| ss_tick | input | 1 | One-cycle step tick from the soft-start oscillator |
| dac_code | output | DW | Reference DAC code in 6.25 mV steps |
| vid_strobe | output | 1 | One-cycle pulse when the target is latched |
| busy | output | 1 | Sequence in progress (includes the invalid-target park) |
| pgood | output | 1 | Power good |

## Verification
The bench measures the boot hold and the power-good delay to the exact cycle. A design that is off by one in either counter, or that strobes the VID at the wrong time, fails these measurements.

It also changes `tgt_code` right after the latch and sets a target below the boot level. A design that tracks the live input, or that can only ramp upward, would end at the wrong code or hang.

The no-load code is presented in each mode both before and after start. A design that checks it in the wrong modes, or keeps checking it after start, either refuses to start or aborts.

Dropping each rail in mid-ramp and after power-good checks that a lost condition always clears the DAC. A monitor checks every DAC change against the tick, catching double steps and untimed steps.

// File: rtl/vrss_pkg.sv
package vrss_pkg;
  typedef enum logic [1:0] {
    MODE_BOOT  = 2'b00,
    MODE_DIR6  = 2'b01,
    MODE_DIR5  = 2'b10,
    MODE_DIR6B = 2'b11
  } vrss_mode_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_DLY,
    ST_RAMP1,
    ST_HOLD,
    ST_RAMP2,
    ST_PGD,
    ST_DONE,
    ST_PARK
  } vrss_state_e;
endpackage

// File: rtl/vrss_start_qual.sv
module vrss_start_qual
  import vrss_pkg::*;
#(
  parameter int VIDW = 6,
  parameter int NLW  = 5
) (
  input  logic            bias_ok,
  input  logic            en_ok,
  input  logic            drv_ok,
  input  logic [1:0]      mode,
  input  logic [VIDW-1:0] vid_code,
  output logic            rails_ok,
  output logic            may_start
);
  logic no_load;

  // R2: all three supply/enable conditions
  assign rails_ok = bias_ok & en_ok & drv_ok;

  // R3: no-load code only matters in the 5-bit direct variant
  generate
    if (VIDW >= NLW) begin : g_nl
      assign no_load = (vrss_mode_e'(mode) == MODE_DIR5) && (&vid_code[NLW-1:0]);
    end else begin : g_nl_narrow
      assign no_load = (vrss_mode_e'(mode) == MODE_DIR5) && (&vid_code);
    end
  endgenerate

  assign may_start = rails_ok & ~no_load;
endmodule

// File: rtl/vrss_interval_timer.sv
module vrss_interval_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q == (limit - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/vrss_dac_stepper.sv
module vrss_dac_stepper #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zero,
  input  logic          enable,
  input  logic          tick,
  input  logic [DW-1:0] goal,
  output logic [DW-1:0] dac,
  output logic          at_goal
);
  assign at_goal = (dac == goal);

  // R11: one LSB per tick, toward the goal in either direction (R6)
  always_ff @(posedge clk) begin
    if (!rst_n)    dac <= '0;
    else if (zero) dac <= '0;
    else if (enable && tick && !at_goal) begin
      if (dac < goal) dac <= dac + 1'b1;
      else            dac <= dac - 1'b1;
    end
  end
endmodule

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq
  import vrss_pkg::*;
#(
  parameter int DW        = 8,
  parameter int VIDW      = 6,
  parameter int BOOT_CODE = 176,
  parameter int T_START   = 110000,
  parameter int T_HOLD    = 9300,
  parameter int T_PG      = 5000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bias_ok,
  input  logic            en_ok,
  input  logic            drv_ok,
  input  logic [1:0]      mode,
  input  logic [VIDW-1:0] vid_code,
  input  logic [DW-1:0]   tgt_code,
  input  logic            tgt_valid,
  input  logic            ss_tick,
  output logic [DW-1:0]   dac_code,
  output logic            vid_strobe,
  output logic            busy,
  output logic            pgood
);
  localparam int TMAX_A = (T_START > T_HOLD) ? T_START : T_HOLD;
  localparam int TMAX   = (TMAX_A > T_PG) ? TMAX_A : T_PG;
  localparam int CW     = $clog2(TMAX + 1);
  localparam logic [DW-1:0] BOOT_Q = DW'(BOOT_CODE);

  vrss_state_e   state_q, state_d;
  vrss_mode_e    mode_q;
  logic [DW-1:0] tgt_q;
  logic          strobe_q;
  logic          latch_now;
  logic          rails_ok, may_start;
  logic          tmr_exp, tmr_clr;
  logic [CW-1:0] tmr_lim;
  logic [DW-1:0] goal;
  logic          at_goal, ramp_en;

  vrss_start_qual #(.VIDW(VIDW)) u_qual (
    .bias_ok  (bias_ok),
    .en_ok    (en_ok),
    .drv_ok   (drv_ok),
    .mode     (mode),
    .vid_code (vid_code),
    .rails_ok (rails_ok),
    .may_start(may_start)
  );

  always_comb begin
    case (state_q)
      ST_HOLD: tmr_lim = CW'(T_HOLD);
      ST_PGD:  tmr_lim = CW'(T_PG);
      default: tmr_lim = CW'(T_START);
    endcase
  end

  assign tmr_clr = (state_d != state_q) || (state_q == ST_OFF);

  vrss_interval_timer #(.CW(CW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (tmr_clr),
    .limit  (tmr_lim),
    .expired(tmr_exp)
  );

  assign goal    = (state_q == ST_RAMP1) ? BOOT_Q : tgt_q;
  assign ramp_en = (state_q == ST_RAMP1) || (state_q == ST_RAMP2);

  vrss_dac_stepper #(.DW(DW)) u_step (
    .clk    (clk),
    .rst_n  (rst_n),
    .zero   (!rails_ok),
    .enable (ramp_en),
    .tick   (ss_tick),
    .goal   (goal),
    .dac    (dac_code),
    .at_goal(at_goal)
  );

  // Sequencer: R4..R9, with R10 overriding every state
  always_comb begin
    state_d = state_q;
    if (!rails_ok) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:   if (may_start) state_d = ST_DLY;
        ST_DLY:   if (tmr_exp) state_d = (mode_q == MODE_BOOT) ? ST_RAMP1 : ST_RAMP2;
        ST_RAMP1: if (at_goal) state_d = ST_HOLD;
        ST_HOLD:  if (tmr_exp) state_d = tgt_valid ? ST_RAMP2 : ST_PARK;
        ST_RAMP2: if (at_goal) state_d = ST_PGD;
        ST_PGD:   if (tmr_exp) state_d = ST_DONE;
        default:  state_d = state_q;
      endcase
    end
  end

  // R5 / R8: target latch points
  assign latch_now = rails_ok &&
                     (((state_q == ST_OFF) && may_start && (vrss_mode_e'(mode) != MODE_BOOT)) ||
                      ((state_q == ST_HOLD) && tmr_exp));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_OFF;
      mode_q   <= MODE_BOOT;
      tgt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      strobe_q <= latch_now;
      if (state_q == ST_OFF) mode_q <= vrss_mode_e'(mode);
      if (latch_now) tgt_q <= tgt_code;
    end
  end

  assign vid_strobe = strobe_q;
  assign busy       = (state_q != ST_OFF) && (state_q != ST_DONE);
  assign pgood      = (state_q == ST_DONE);
endmodule

// File: rtl/vrss_checker.sv
module vrss_checker #(
  parameter int DW   = 8,
  parameter int VIDW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bias_ok,
  input logic            en_ok,
  input logic            drv_ok,
  input logic [1:0]      mode,
  input logic [VIDW-1:0] vid_code,
  input logic            ss_tick,
  input logic [DW-1:0]   dac_code,
  input logic            vid_strobe,
  input logic            busy,
  input logic            pgood
);
  logic ok;
  assign ok = bias_ok && en_ok && drv_ok;

  p_off_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ok |=> (dac_code == '0) && !busy && !pgood);

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pgood && !ok) |=> !busy);

  p_noload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pgood && (mode == 2'b10) && (&vid_code[4:0])) |=> !busy);

  p_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !ss_tick) |=> $stable(dac_code));

  p_step_size_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ok |=> (({1'b0, dac_code} == {1'b0, $past(dac_code)}) ||
            ({1'b0, dac_code} == {1'b0, $past(dac_code)} + 1'b1) ||
            ({1'b0, dac_code} + 1'b1 == {1'b0, $past(dac_code)})));

  p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vid_strobe |=> !vid_strobe);

  p_pgood_settled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> !busy && $stable(dac_code));
endmodule

bind vr_softstart_seq vrss_checker #(.DW(DW), .VIDW(VIDW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bias_ok   (bias_ok),
  .en_ok     (en_ok),
  .drv_ok    (drv_ok),
  .mode      (mode),
  .vid_code  (vid_code),
  .ss_tick   (ss_tick),
  .dac_code  (dac_code),
  .vid_strobe(vid_strobe),
  .busy      (busy),
  .pgood     (pgood)
);

// File: tb/sim_vr_softstart_seq.sv
module sim_vr_softstart_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, VIDW = 6, BOOT = 176;
  localparam int TS = 20, TH = 7, TP = 5, TICK_DIV = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bias_ok = 0, en_ok = 0, drv_ok = 0, tgt_valid = 1, ss_tick = 0;
  logic [1:0] mode = 2'b00;
  logic [VIDW-1:0] vid_code = '0;
  logic [DW-1:0] tgt_code = '0, dac_code;
  logic vid_strobe, busy, pgood;

  int checks = 0, errors = 0, step_err = 0, strobes = 0, dac_max = 0;
  bit done = 0;

  vr_softstart_seq #(.DW(DW), .VIDW(VIDW), .BOOT_CODE(BOOT),
    .T_START(TS), .T_HOLD(TH), .T_PG(TP)) u0 (
    .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .en_ok(en_ok), .drv_ok(drv_ok),
    .mode(mode), .vid_code(vid_code), .tgt_code(tgt_code), .tgt_valid(tgt_valid),
    .ss_tick(ss_tick), .dac_code(dac_code), .vid_strobe(vid_strobe),
    .busy(busy), .pgood(pgood));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Tick source and step monitor (R11) in one block to keep ordering fixed
  int div = 0, prev_dac = 0;
  bit last_tick = 0;
  always @(negedge clk) begin
    if (int'(dac_code) != prev_dac && dac_code != 0) begin
      if (!last_tick) step_err++;
      if (int'(dac_code) - prev_dac > 1 || prev_dac - int'(dac_code) > 1) step_err++;
    end
    if (int'(dac_code) > dac_max) dac_max = int'(dac_code);
    if (vid_strobe) strobes++;
    prev_dac = int'(dac_code);
    div = (div + 1) % TICK_DIV;
    ss_tick = (div == 0);
    last_tick = ss_tick;
  end

  task automatic check(bit cond, string req, string what, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rails(bit v);
    bias_ok = v; en_ok = v; drv_ok = v;
  endtask

  task automatic shutdown();
    rails(0); cyc(3);
  endtask

  task automatic wait_dac(int v, string req);
    int g = 0;
    while (int'(dac_code) != v && g < 3000) begin cyc(1); g++; end
    check(int'(dac_code) == v, req, "dac reaches value", int'(dac_code), v);
  endtask

  // returns cycles until strobe
  task automatic wait_strobe(output int k);
    k = 0;
    while (!vid_strobe && k < 3000) begin cyc(1); k++; end
  endtask

  task automatic wait_pg(output int k);
    k = 0;
    while (!pgood && k < 3000) begin cyc(1); k++; end
  endtask

  task automatic t_reset();
    rst_n = 0; cyc(3); rst_n = 1; cyc(2);
    check(dac_code == 0 && !busy && !pgood && !vid_strobe, "R1", "idle outputs after reset",
          {dac_code, busy, pgood, vid_strobe}, 0);
  endtask

  task automatic t_gate();
    mode = 2'b00; tgt_code = 8'd200; tgt_valid = 1;
    for (int k = 0; k < 3; k++) begin
      bias_ok = (k != 0); en_ok = (k != 1); drv_ok = (k != 2);
      cyc(30);
      check(!busy && dac_code == 0, "R2", "start blocked with one flag low", busy, 0);
    end
    shutdown();
  endtask

  task automatic t_boot_up();
    int k; bit bad = 0;
    mode = 2'b00; tgt_code = 8'd200; tgt_valid = 1; strobes = 0; step_err = 0;
    rails(1);
    cyc(1);
    check(busy, "R4", "busy after start", busy, 1);
    for (int i = 0; i < TS; i++) begin if (dac_code != 0) bad = 1; cyc(1); end
    check(!bad, "R4", "dac held at 0 during start delay", bad, 0);
    wait_dac(BOOT, "R4");
    wait_strobe(k);
    check(k == TH + 1, "R5", "cycles from boot level to strobe", k, TH + 1);
    check(dac_code == BOOT, "R5", "dac at boot level at strobe", dac_code, BOOT);
    tgt_code = 8'd50;  // must be ignored (R6)
    wait_dac(200, "R6");
    wait_pg(k);
    check(k == TP + 1, "R9", "cycles from target to pgood", k, TP + 1);
    check(dac_code == 200 && !busy, "R9", "dac stays at target, busy low", dac_code, 200);
    cyc(20);
    check(dac_code == 200 && pgood, "R6", "late target change ignored", dac_code, 200);
    check(strobes == 1, "R5", "single strobe per sequence", strobes, 1);
    check(step_err == 0, "R11", "steps only on tick, one LSB", step_err, 0);
    en_ok = 0; cyc(1);
    check(dac_code == 0 && !pgood && !busy, "R10", "enable loss clears outputs", dac_code, 0);
    shutdown();
  endtask

  task automatic t_boot_down();
    int k;
    mode = 2'b00; tgt_code = 8'd100; tgt_valid = 1; dac_max = 0;
    rails(1);
    wait_dac(BOOT, "R4");
    wait_strobe(k);
    wait_dac(100, "R6");
    check(dac_max == BOOT, "R6", "downward ramp peak is boot level", dac_max, BOOT);
    wait_pg(k);
    check(k == TP + 1 && dac_code == 100, "R9", "pgood after downward ramp", k, TP + 1);
    shutdown();
  endtask

  task automatic t_boot_invalid();
    int k;
    mode = 2'b00; tgt_code = 8'd200; tgt_valid = 0; dac_max = 0;
    rails(1);
    wait_strobe(k);
    tgt_valid = 1;
    cyc(100);
    check(dac_code == BOOT && !pgood && busy, "R7", "parked at boot level", dac_code, BOOT);
    check(dac_max == BOOT, "R7", "no ramp past boot level", dac_max, BOOT);
    shutdown();
  endtask

  task automatic t_direct();
    int k; bit bad = 0;
    mode = 2'b01; tgt_code = 8'd40; tgt_valid = 1; dac_max = 0; strobes = 0;
    rails(1);
    cyc(1);
    check(vid_strobe, "R8", "strobe in first cycle after start", vid_strobe, 1);
    tgt_code = 8'd90;  // ignored after latch
    for (int i = 0; i < TS - 1; i++) begin if (dac_code != 0) bad = 1; cyc(1); end
    check(!bad, "R8", "dac at 0 during direct delay", bad, 0);
    wait_dac(40, "R8");
    wait_pg(k);
    check(k == TP + 1, "R9", "direct mode pgood delay", k, TP + 1);
    check(dac_max == 40 && strobes == 1, "R8", "single ramp to latched target", dac_max, 40);
    shutdown();
  endtask

  task automatic t_noload();
    int k;
    mode = 2'b10; vid_code = 6'h1F; tgt_code = 8'd30;
    rails(1); cyc(50);
    check(!busy && dac_code == 0, "R3", "no-load code blocks 5-bit start", busy, 0);
    vid_code = 6'h3F; cyc(20);
    check(!busy, "R3", "low five bits all ones still block", busy, 0);
    shutdown();
    mode = 2'b01; vid_code = 6'h1F; rails(1); cyc(2);
    check(busy, "R3", "6-bit direct ignores no-load code", busy, 1);
    shutdown();
    mode = 2'b10; vid_code = 6'h0E; rails(1); cyc(3);
    check(busy, "R3", "5-bit starts with normal code", busy, 1);
    vid_code = 6'h1F;
    wait_pg(k);
    check(pgood && dac_code == 30, "R3", "no-load code after start ignored", dac_code, 30);
    vid_code = '0;
    shutdown();
  endtask

  task automatic t_dropout();
    int k;
    mode = 2'b00; tgt_code = 8'd190; tgt_valid = 1;
    rails(1);
    wait_dac(60, "R10");
    drv_ok = 0; cyc(1);
    check(dac_code == 0 && !busy, "R10", "driver loss mid-ramp clears dac", dac_code, 0);
    drv_ok = 1;
    wait_pg(k);
    check(pgood && dac_code == 190, "R10", "restart reaches target", dac_code, 190);
    bias_ok = 0; cyc(1);
    check(dac_code == 0 && !pgood && !busy, "R10", "bias loss after pgood", pgood, 0);
    shutdown();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete actual=1 expected=0");
    finish_run();
  end

  initial begin
    cyc(1);
    t_reset();
    t_gate();
    t_boot_up();
    t_boot_down();
    t_boot_invalid();
    t_direct();
    t_noload();
    t_dropout();
    finish_run();
  end
endmodule